// File: doc/BRIEF.md
# Dual gated timer/counter with cascade, reload and split modes

This block holds two timer/counter units behind one byte-wide register port. Each unit has a low and a high count byte. A unit counts one of two sources. The first is a tick that the block makes by dividing the module clock by six. The second is a falling edge on that unit's external count pin. A per-unit run bit enables counting, and a per-unit gate enable can also make counting wait for the unit's external gate pin to be high. When a unit's count wraps, the unit raises an overflow flag that drives its interrupt request line. The flag stays set until the matching acknowledge input is asserted.

Three counting arrangements are offered. In the cascaded arrangement both bytes form one 16-bit up-counter. In the reload arrangement only the low byte counts, and it refills from the high byte each time it wraps. In the split arrangement, which only unit 0 has, unit 0 becomes two 8-bit timers. The second of these timers is controlled by unit 1's run bit and reports through unit 1's flag. The count pins and gate pins are asynchronous and pass through a two-stage synchroniser before use.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all six registers read zero and both interrupt lines are low. Register addresses: 0 = unit 0 low byte, 1 = unit 0 high byte, 2 = unit 1 low byte, 3 = unit 1 high byte, 4 = mode, 5 = control. Mode register: bits [3:0] configure unit 0 and bits [7:4] configure unit 1; within each nibble, [1:0] is the arrangement (00 hold, 01 cascaded, 10 reload, 11 split), bit 2 selects the external pin as source, and bit 3 enables gating. Control register: bit 0 is run for unit 0 and bit 1 is run for unit 1 (both writable); bits 4 and 5 are the overflow flags of unit 0 and unit 1 (read-only).
- R2: In the cascaded arrangement with the internal source, the time between overflows equals 6 × (65536 − V) clock cycles, where V is the 16-bit value loaded as {high, low}.
- R3: In the cascaded arrangement, a carry out of the low byte increments the high byte, so {0x12, 0xFE} followed by two count events reads {0x13, 0x00}.
- R4: With the external source selected, the count advances by exactly one for each high-to-low transition of the count pin, and a rising transition alone does not advance it.
- R5: When gating is enabled, count events are ignored while the gate pin is low and are counted while it is high.
- R6: With the run bit clear, the count registers hold their value whatever the source does.
- R7: In the reload arrangement, the time between overflows equals 6 × (256 − H), where H is the high byte. The high byte is never altered by a reload. A new H written during an interval takes effect from the following overflow.
- R8: An overflow flag, and the interrupt line it drives, stays set until the matching acknowledge is asserted, and is clear one cycle after the acknowledge.
- R9: In the split arrangement, unit 0's low byte is an 8-bit counter that uses unit 0's source, gate and run bits. It sets unit 0's flag, with period 6 × (256 − L) when it is reloaded with L after each overflow.
- R10: In the split arrangement, unit 0's high byte always counts the divide-by-6 tick, whatever unit 0's source select is. It runs on unit 1's run bit, and its overflow sets unit 1's flag, with period 6 × (256 − H) when it is reloaded with H.
- R11: While unit 0 is in the split arrangement, unit 1 still counts, but its own wrap does not set unit 1's flag.
- R12: A register write to a count byte wins over an increment or reload of that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| cnt_pin | input | 2 | External count pins, one per unit |
| gate_pin | input | 2 | External gate pins, one per unit |
| irq_ack | input | 2 | Interrupt acknowledge, one per unit |
| irq | output | 2 | Interrupt requests (overflow flags) |

## Verification
The hardest cases to reach from the ports are those where two events land on the same clock edge. One is a software write against a prescaler tick. The other is a new reload value that arrives during an interval already in progress. For the first, the bench writes the low byte on every cycle for longer than two prescaler periods and reads it back after each edge, so at least two ticks collide with a write. For the second, the bench services each interrupt at a fixed cycle after the flag rises, writing back the count and acknowledging there. This fixes the phase of the tick relative to the counter, so every overflow interval can be predicted exactly. A scoreboard then compares each measured interval with the value computed from the formula.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      MD_HOLD   = 2'b00,
      MD_CASC   = 2'b01,
      MD_RELOAD = 2'b10,
      MD_SPLIT  = 2'b11
   } tmr_mode_e;

   typedef struct packed {
      logic      gate_en;
      logic      sel_ext;
      tmr_mode_e mode;
   } unit_cfg_t;

   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_LO0  = 3'd0;
   localparam logic [ADDR_W-1:0] A_HI0  = 3'd1;
   localparam logic [ADDR_W-1:0] A_LO1  = 3'd2;
   localparam logic [ADDR_W-1:0] A_HI1  = 3'd3;
   localparam logic [ADDR_W-1:0] A_MODE = 3'd4;
   localparam logic [ADDR_W-1:0] A_CTRL = 3'd5;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int DIV = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("tmr_prescale: DIV must be at least 2");
   end

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + PW'(1);
   end

   assign tick_o = (cnt_q == LAST);

   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_insync.sv
module tmr_insync #(
   parameter int N      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_insync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < N; g++) begin : g_pin
      logic [STAGES-1:0] sh_q;
      logic              prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
         end else begin
            sh_q   <= {sh_q[STAGES-2:0], pin_i[g]};
            prev_q <= sh_q[STAGES-1];
         end
      end

      assign lvl_o[g]  = sh_q[STAGES-1];
      assign fall_o[g] = prev_q & ~sh_q[STAGES-1];

      // R4
      fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fall_o[g] |=> !fall_o[g]);
   end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int CW       = 8,
   parameter int SPLIT_OK = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  unit_cfg_t     cfg_i,
   input  logic          run_i,
   input  logic          hi_run_i,
   input  logic          tick_i,
   input  logic          ext_fall_i,
   input  logic          gate_lvl_i,
   input  logic          wr_lo_i,
   input  logic          wr_hi_i,
   input  logic [CW-1:0] wr_data_i,
   output logic [CW-1:0] lo_o,
   output logic [CW-1:0] hi_o,
   output logic          ovf_o,
   output logic          hovf_o
);
   localparam int  W2       = 2 * CW;
   localparam bit  SPLIT_ON = (SPLIT_OK != 0);

   logic [CW-1:0] lo_q, hi_q, lo_n, hi_n;
   logic          src_ev, go, inc;

   assign src_ev = cfg_i.sel_ext ? ext_fall_i : tick_i;
   assign go     = run_i & (~cfg_i.gate_en | gate_lvl_i);
   assign inc    = go & src_ev;

   always_comb begin
      lo_n   = lo_q;
      hi_n   = hi_q;
      ovf_o  = 1'b0;
      hovf_o = 1'b0;
      case (cfg_i.mode)
         MD_CASC: begin
            if (inc) begin
               {hi_n, lo_n} = {hi_q, lo_q} + W2'(1);
               ovf_o        = &{hi_q, lo_q};
            end
         end
         MD_RELOAD: begin
            if (inc) begin
               if (&lo_q) begin
                  lo_n  = hi_q;
                  ovf_o = 1'b1;
               end else begin
                  lo_n  = lo_q + CW'(1);
               end
            end
         end
         MD_SPLIT: begin
            if (SPLIT_ON) begin
               if (inc) begin
                  lo_n  = lo_q + CW'(1);
                  ovf_o = &lo_q;
               end
               if (hi_run_i && tick_i) begin
                  hi_n   = hi_q + CW'(1);
                  hovf_o = &hi_q;
               end
            end
         end
         default: ;
      endcase
      if (wr_lo_i) lo_n = wr_data_i;
      if (wr_hi_i) hi_n = wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end

   assign lo_o = lo_q;
   assign hi_o = hi_q;

   // R7
   reload_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.mode == MD_RELOAD && inc && (&lo_q) && !wr_lo_i) |=> lo_q == $past(hi_q));
   // R7
   hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.mode == MD_RELOAD && !wr_hi_i) |=> $stable(hi_q));
   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !hi_run_i && !wr_lo_i && !wr_hi_i) |=> $stable({hi_q, lo_q}));
   // R12
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo_i |=> lo_q == $past(wr_data_i));
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pkg::*;
#(
   parameter int CW       = 8,
   parameter int PRESCALE = 6,
   parameter int SYNC_N   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CW-1:0]     wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CW-1:0]     rd_data,
   input  logic [1:0]        cnt_pin,
   input  logic [1:0]        gate_pin,
   input  logic [1:0]        irq_ack,
   output logic [1:0]        irq
);
   localparam int UNITS = 2;

   if (CW < 8) begin : g_bad_cw
      $error("tmr_pair: CW must be at least 8");
   end

   logic              tick;
   logic [UNITS-1:0]  gate_lvl, cnt_fall;
   unit_cfg_t         cfg_q [UNITS];
   logic [UNITS-1:0]  run_q, flag_q, flag_set;
   logic [UNITS-1:0]  ovf, hovf;
   logic [CW-1:0]     lo [UNITS];
   logic [CW-1:0]     hi [UNITS];
   logic              split0;

   tmr_prescale #(.DIV(PRESCALE)) i_pre (
      .clk(clk), .rst_n(rst_n), .tick_o(tick)
   );

   tmr_insync #(.N(2 * UNITS), .STAGES(SYNC_N)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .pin_i({gate_pin, cnt_pin}),
      .lvl_o({gate_lvl, cnt_lvl_unused_guard}),
      .fall_o({gate_fall_unused_guard, cnt_fall})
   );

   logic [UNITS-1:0] cnt_lvl_unused_guard, gate_fall_unused_guard;

   for (genvar u = 0; u < UNITS; u++) begin : g_unit
      tmr_unit #(.CW(CW), .SPLIT_OK(u == 0 ? 1 : 0)) i_unit (
         .clk(clk), .rst_n(rst_n),
         .cfg_i(cfg_q[u]),
         .run_i(run_q[u]),
         .hi_run_i(u == 0 ? run_q[1] : 1'b0),
         .tick_i(tick),
         .ext_fall_i(cnt_fall[u]),
         .gate_lvl_i(gate_lvl[u]),
         .wr_lo_i(wr_en && wr_addr == ADDR_W'(2 * u)),
         .wr_hi_i(wr_en && wr_addr == ADDR_W'(2 * u + 1)),
         .wr_data_i(wr_data),
         .lo_o(lo[u]),
         .hi_o(hi[u]),
         .ovf_o(ovf[u]),
         .hovf_o(hovf[u])
      );
   end

   assign split0      = (cfg_q[0].mode == MD_SPLIT);
   assign flag_set[0] = ovf[0];
   assign flag_set[1] = split0 ? hovf[0] : (ovf[1] | hovf[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q[0] <= '0;
         cfg_q[1] <= '0;
         run_q    <= '0;
         flag_q   <= '0;
      end else begin
         if (wr_en && wr_addr == A_MODE) begin
            cfg_q[0] <= unit_cfg_t'(wr_data[3:0]);
            cfg_q[1] <= unit_cfg_t'(wr_data[7:4]);
         end
         if (wr_en && wr_addr == A_CTRL) run_q <= wr_data[1:0];
         for (int u = 0; u < UNITS; u++) begin
            if (flag_set[u])     flag_q[u] <= 1'b1;
            else if (irq_ack[u]) flag_q[u] <= 1'b0;
         end
      end
   end

   assign irq = flag_q;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_LO0:   rd_data = lo[0];
         A_HI0:   rd_data = hi[0];
         A_LO1:   rd_data = lo[1];
         A_HI1:   rd_data = hi[1];
         A_MODE:  rd_data[7:0] = {cfg_q[1], cfg_q[0]};
         A_CTRL:  rd_data[7:0] = {2'b00, flag_q, 2'b00, run_q};
         default: rd_data = '0;
      endcase
   end

   // R8
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[0] && !flag_set[0]) |=> !irq[0]);
   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[1] && !irq_ack[1]) |=> irq[1]);
   // R11
   split_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (split0 && !hovf[0] && !irq[1]) |=> !irq[1]);
endmodule

// File: tb/test_tmr_pair.sv
module test_tmr_pair;
   localparam int CLK_PERIOD = 10;
   localparam int PRE = 6;
   localparam logic [2:0] LO0 = 3'd0, HI0 = 3'd1, LO1 = 3'd2, HI1 = 3'd3,
                          MODE = 3'd4, CTRL = 3'd5;

   typedef struct {
      int    per;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [1:0] cnt_pin = '0;
   logic [1:0] gate_pin = '0;
   logic [1:0] irq_ack = '0;
   logic [1:0] irq;

   int n_cmp = 0, n_bad = 0, cyc = 0, epoch = 0;
   exp_t q0[$], q1[$];
   int   last_t[2];
   int   ep_t[2];
   bit   have_t[2];
   logic [1:0] prev_irq = '0;

   tmr_pair i_tmr_pair (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .cnt_pin(cnt_pin), .gate_pin(gate_pin), .irq_ack(irq_ack), .irq(irq)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string tag, int got, int exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // Monitor: measures intervals between rising interrupt lines, pops expectations
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n) begin
         for (int k = 0; k < 2; k++) begin
            if (irq[k] && !prev_irq[k]) begin
               if (have_t[k] && ep_t[k] == epoch) begin
                  if (k == 0 && q0.size() > 0) begin
                     e = q0.pop_front();
                     chk(e.tag, cyc - last_t[k], e.per);
                  end else if (k == 1 && q1.size() > 0) begin
                     e = q1.pop_front();
                     chk(e.tag, cyc - last_t[k], e.per);
                  end
               end
               last_t[k] = cyc;
               have_t[k] = 1'b1;
               ep_t[k]   = epoch;
            end
         end
         prev_irq = irq;
      end
   end

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic rdchk(string tag, logic [2:0] a, logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(tag, int'(d), int'(exp));
   endtask

   task automatic pulse(int k);
      @(negedge clk) cnt_pin[k] = 1'b1;
      repeat (5) @(negedge clk);
      cnt_pin[k] = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic wait_rise(int k);
      do @(negedge clk); while (irq[k] !== 1'b1);
   endtask

   // Driver-side service: acknowledge now, optional writes at the next two edges
   task automatic ack_load(int k, bit w1, logic [2:0] a1, logic [7:0] d1,
                           bit w2, logic [2:0] a2, logic [7:0] d2);
      irq_ack[k] = 1'b1;
      if (w1) begin wr_en = 1'b1; wr_addr = a1; wr_data = d1; end
      @(negedge clk);
      irq_ack[k] = 1'b0;
      wr_en = 1'b0;
      if (w2) begin wr_en = 1'b1; wr_addr = a2; wr_data = d2; end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic push(int k, int per, string tag, int n);
      exp_t e;
      e.per = per; e.tag = tag;
      for (int i = 0; i < n; i++) begin
         if (k == 0) q0.push_back(e); else q1.push_back(e);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : drive
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 6; a++) rdchk("R1 reset register", 3'(a), 8'h00);
      chk("R1 irq reset", int'(irq), 0);

      // R12: continuous low-byte writes while ticking
      wr(MODE, 8'h01);
      wr(CTRL, 8'h01);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = LO0; wr_data = 8'h55;
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         rd_addr = LO0;
         #1 chk("R12 write beats tick", int'(rd_data), 'h55);
      end
      wr_en = 1'b0;
      wr(CTRL, 8'h00);

      // R6: stopped timer holds
      wr(LO0, 8'h10);
      wr(HI0, 8'h00);
      repeat (30) @(negedge clk);
      rdchk("R6 run clear holds low", LO0, 8'h10);
      rdchk("R6 run clear holds high", HI0, 8'h00);

      // R3/R4: unit 1 cascaded on external pin
      wr(MODE, 8'h50);
      wr(LO1, 8'hFE);
      wr(HI1, 8'h12);
      wr(CTRL, 8'h02);
      @(negedge clk) cnt_pin[1] = 1'b1;
      repeat (8) @(negedge clk);
      rdchk("R4 rising edge ignored", LO1, 8'hFE);
      cnt_pin[1] = 1'b0;
      repeat (8) @(negedge clk);
      rdchk("R4 falling edge counts", LO1, 8'hFF);
      pulse(1);
      rdchk("R3 carry low", LO1, 8'h00);
      rdchk("R3 carry high", HI1, 8'h13);
      repeat (3) pulse(1);
      rdchk("R4 three pulses", LO1, 8'h03);
      wr(CTRL, 8'h00);

      // R5/R6: gating on unit 0 external pin
      wr(MODE, 8'h0D);
      wr(LO0, 8'h00);
      wr(HI0, 8'h00);
      wr(CTRL, 8'h01);
      gate_pin[0] = 1'b0;
      repeat (3) pulse(0);
      rdchk("R5 gate low blocks", LO0, 8'h00);
      gate_pin[0] = 1'b1;
      repeat (2) pulse(0);
      rdchk("R5 gate high counts", LO0, 8'h02);
      wr(CTRL, 8'h00);
      repeat (2) pulse(0);
      rdchk("R6 run clear ignores pin", LO0, 8'h02);
      gate_pin[0] = 1'b0;

      // R11: split mode mutes unit 1's own wrap
      wr(MODE, 8'h53);
      wr(LO0, 8'h00);
      wr(HI0, 8'h00);
      wr(LO1, 8'hFF);
      wr(HI1, 8'hFF);
      wr(CTRL, 8'h02);
      pulse(1);
      rdchk("R11 unit1 still counts low", LO1, 8'h00);
      rdchk("R11 unit1 still counts high", HI1, 8'h00);
      chk("R11 unit1 flag stays clear", int'(irq[1]), 0);
      wr(CTRL, 8'h00);

      // R8: flag persists until acknowledged
      wr(MODE, 8'h50);
      wr(LO1, 8'hFF);
      wr(HI1, 8'hFF);
      wr(CTRL, 8'h02);
      pulse(1);
      repeat (40) @(negedge clk);
      chk("R8 flag held without ack", int'(irq[1]), 1);
      rdchk("R8 flag visible in control", CTRL, 8'h22);
      irq_ack[1] = 1'b1;
      @(negedge clk);
      irq_ack[1] = 1'b0;
      chk("R8 ack clears flag", int'(irq[1]), 0);
      wr(CTRL, 8'h00);

      // R2: cascaded internal periods
      wr(MODE, 8'h01);
      wr(LO0, 8'hF0);
      wr(HI0, 8'hFF);
      epoch++;
      push(0, PRE * (65536 - 'hFFF0), "R2 period FFF0", 3);
      wr(CTRL, 8'h01);
      repeat (4) begin
         wait_rise(0);
         ack_load(0, 1, LO0, 8'hF0, 1, HI0, 8'hFF);
      end
      wr(CTRL, 8'h00);
      wr(LO0, 8'h00);
      wr(HI0, 8'hFF);
      epoch++;
      push(0, PRE * (65536 - 'hFF00), "R2 period FF00", 2);
      wr(CTRL, 8'h01);
      repeat (3) begin
         wait_rise(0);
         ack_load(0, 1, LO0, 8'h00, 1, HI0, 8'hFF);
      end
      wr(CTRL, 8'h00);

      // R7: reload periods and mid-run reload change
      wr(MODE, 8'h02);
      wr(HI0, 8'hF0);
      wr(LO0, 8'hF0);
      epoch++;
      push(0, PRE * (256 - 'hF0), "R7 reload F0", 2);
      push(0, PRE * (256 - 'hE0), "R7 reload E0", 2);
      wr(CTRL, 8'h01);
      wait_rise(0);
      ack_load(0, 0, LO0, 8'h00, 0, LO0, 8'h00);
      wait_rise(0);
      ack_load(0, 1, HI0, 8'hE0, 0, LO0, 8'h00);
      repeat (3) begin
         wait_rise(0);
         ack_load(0, 0, LO0, 8'h00, 0, LO0, 8'h00);
      end
      rdchk("R7 high byte kept", HI0, 8'hE0);
      wr(CTRL, 8'h00);

      // R9: split low byte on unit 0 controls
      wr(MODE, 8'h03);
      wr(LO0, 8'hF0);
      epoch++;
      push(0, PRE * (256 - 'hF0), "R9 split low period", 3);
      wr(CTRL, 8'h01);
      repeat (4) begin
         wait_rise(0);
         ack_load(0, 1, LO0, 8'hF0, 0, LO0, 8'h00);
      end
      wr(CTRL, 8'h00);

      // R10: split high byte on unit 1 run/flag, source select ignored
      wr(MODE, 8'h07);
      wr(LO0, 8'h33);
      wr(HI0, 8'hE0);
      epoch++;
      push(1, PRE * (256 - 'hE0), "R10 split high period", 3);
      wr(CTRL, 8'h02);
      repeat (4) begin
         wait_rise(1);
         ack_load(1, 1, HI0, 8'hE0, 0, LO0, 8'h00);
      end
      chk("R10 unit0 flag untouched", int'(irq[0]), 0);
      rdchk("R9 low byte idle without unit0 run", LO0, 8'h33);
      wr(CTRL, 8'h00);

      chk("R2 R7 R9 R10 all expectations consumed", q0.size() + q1.size(), 0);
      rd(CTRL, d);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule